// File: doc/BRIEF.md
# Serial Transmitter with Break Override

This block is the transmit side of an asynchronous serial port. Words of 8 or 9 bits are written into a four-entry holding buffer. On a baud tick, the oldest word moves into a shift register, which sends it as a frame. The frame has a low start bit, the data bits least significant first, and one or two high stop bits. Each bit lasts exactly one baud tick. The next word is loaded on the tick that ends the previous frame's last stop bit, so a full buffer drains with no gap between frames.

Each hand-off from buffer to shift register can raise a single-cycle interrupt pulse. The select input chooses the policy. In one policy, every hand-off pulses, which tells software that a slot has opened. In the other, only a hand-off that leaves the buffer empty pulses. The select input is sampled at each hand-off, so it can change while words are flowing. A break input drives the line low at once, whatever is being sent, and it blocks hand-offs while it is high. A break therefore never causes an interrupt. Software holds break for at least 13 baud ticks and then releases it, and the line returns high to form the stop level.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `tx_idle` is 1, `buf_full` is 0 and `tx_irq` is 0.
- R2: The buffer holds 4 words. `buf_full` is 1 exactly when 4 words are held. A write made while `buf_full` is 1 is ignored: the word is never sent and the buffer content is unchanged.
- R3: A frame is one start bit of 0, then the data bits least significant first (9 bits when `nine_bit` is 1, otherwise bits 7..0), then stop bits of 1 (two when `two_stop` is 1, otherwise one). Each bit is held from one baud tick to the next. A hand-off happens only on a cycle where `baud_tick` is 1. `nine_bit` and `two_stop` are sampled at the hand-off.
- R4: When the buffer holds a word, the hand-off happens on the tick that ends the last stop bit of the current frame, with no idle bit in between. From idle, it happens on the first tick that finds a word in the buffer.
- R5: With `irq_sel` at 0, `tx_irq` is high for exactly one cycle, the cycle after each hand-off.
- R6: With `irq_sel` at 1, `tx_irq` pulses the cycle after a hand-off only if that hand-off leaves the buffer empty. An accepted write in the same cycle counts as refilling the buffer.
- R7: `irq_sel` is taken at the hand-off cycle, so a change of `irq_sel` applies from the next hand-off.
- R8: While `brk` is 1, `txd` is 0 in the same cycle, even in the middle of a frame.
- R9: While `brk` is 1, no hand-off happens and `tx_irq` stays 0. Once `brk` is 0 and no frame is active, `txd` is 1.
- R10: `tx_idle` is 1 exactly when the buffer is empty, no frame is being shifted and `brk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| baud_tick | input | 1 | One-cycle pulse marking each bit period |
| wr_en | input | 1 | Write strobe into the buffer |
| wr_data | input | 9 | Word to send (bit 8 is used in 9-bit mode only) |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| irq_sel | input | 1 | 0: pulse on every hand-off, 1: pulse only when the buffer drains |
| brk | input | 1 | Break: forces the line low and stalls hand-offs |
| txd | output | 1 | Serial line, idles high |
| buf_full | output | 1 | Buffer holds 4 words |
| tx_idle | output | 1 | Nothing buffered, nothing shifting, no break |
| tx_irq | output | 1 | Single-cycle transmit interrupt pulse |

## Verification
The hardest cases to reach from the ports involve timing between two events. One is a hand-off that exactly empties the buffer while a write lands in the same cycle. Another is a write into a full buffer. A third is a break that starts in the middle of a frame. To reach a full buffer, the stimulus fills it while a break holds off all hand-offs, then writes a fifth word. It then releases the break and watches four back-to-back frames. The baud divisor is also set to 1 so that ticks come every cycle, and a word is written on the same cycle as a hand-off, which puts the refill and the drain in one edge. A behavioural queue model predicts every output in every cycle, including under `irq_sel` changes in mid-stream.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned MAX_DATA_W = 9;
  localparam int unsigned MAX_STOP_W = 2;
  localparam int unsigned FRAME_W    = 1 + MAX_DATA_W + MAX_STOP_W;
  typedef logic [MAX_DATA_W-1:0] word_t;
endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sertx_buf.sv
module sertx_buf #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         one_left,
  output logic         accepted
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count_q == CNT_FULL);
  assign empty    = (count_q == '0);
  assign one_left = (count_q == CNT_W'(1));
  assign accepted = push_req && !full;
  assign rdata    = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (accepted) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)      rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({accepted, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accepted && (wr_ptr_q == PTR_W'(i))) mem_q[i] <= wdata;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL);
  // R2
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> (full && $stable(wr_ptr_q)));
  // R2
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  input  logic              nine,
  input  logic              two_stop,
  output logic              bit_out,
  output logic              busy,
  output logic              last_bit
);
  localparam int unsigned FW      = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FW + 1);
  localparam int unsigned LAST_MIN = DATA_W;

  logic [FW-1:0]    sh_q, sh_d, frame_w;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d, last_w;
  logic             busy_q, busy_d;

  always_comb begin
    frame_w           = '1;
    frame_w[0]        = 1'b0;
    frame_w[DATA_W:1] = ldata;
    if (!nine) frame_w[DATA_W] = 1'b1;
    last_w = CNT_W'(LAST_MIN) + CNT_W'(nine) + CNT_W'(two_stop);
  end

  assign last_bit = busy_q && (cnt_q == last_q);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = frame_w;
      cnt_d  = '0;
      last_d = last_w;
      busy_d = 1'b1;
    end else if (tick && busy_q) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[FW-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign bit_out = busy_q ? sh_q[0] : 1'b1;

  // R3
  load_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> tick);
  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !load) |=> ($stable(sh_q) && $stable(cnt_q)));
  // R3
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !bit_out));
endmodule

// File: rtl/sertx_irq.sv
module sertx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic handoff,
  input  logic drain_only,
  input  logic leaves_empty,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb irq_d = handoff && (!drain_only || leaves_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R6
  drain_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && drain_only && !leaves_empty) |=> !irq_q);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = sertx_pkg::MAX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nine_bit,
  input  logic              two_stop,
  input  logic              irq_sel,
  input  logic              brk,
  output logic              txd,
  output logic              buf_full,
  output logic              tx_idle,
  output logic              tx_irq
);
  logic              rst_i_n;
  logic [DATA_W-1:0] head;
  logic              buf_empty, buf_one, buf_acc;
  logic              sh_bit, sh_busy, sh_last;
  logic              handoff, leaves_empty;

  sertx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sertx_buf #(.DEPTH(DEPTH), .W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .push_req (wr_en),
    .wdata    (wr_data),
    .pop      (handoff),
    .rdata    (head),
    .full     (buf_full),
    .empty    (buf_empty),
    .one_left (buf_one),
    .accepted (buf_acc)
  );

  always_comb begin
    handoff      = baud_tick && !brk && !buf_empty && (!sh_busy || sh_last);
    leaves_empty = buf_one && !buf_acc;
  end

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (baud_tick),
    .load     (handoff),
    .ldata    (head),
    .nine     (nine_bit),
    .two_stop (two_stop),
    .bit_out  (sh_bit),
    .busy     (sh_busy),
    .last_bit (sh_last)
  );

  sertx_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .handoff      (handoff),
    .drain_only   (irq_sel),
    .leaves_empty (leaves_empty),
    .irq          (tx_irq)
  );

  assign txd     = brk ? 1'b0 : sh_bit;
  assign tx_idle = buf_empty && !sh_busy && !brk;

  // R9
  brk_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    brk |=> !tx_irq);
  // R10
  idle_not_full_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    tx_idle |-> (!buf_full && txd));
  // R4
  reload_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sh_last && baud_tick && !brk && !buf_empty) |=> sh_busy);
endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       nine_bit = 1'b0;
  logic       two_stop = 1'b0;
  logic       irq_sel = 1'b0;
  logic       brk = 1'b0;
  logic       txd, buf_full, tx_idle, tx_irq;

  int vectors = 0;
  int misses  = 0;
  int div     = 4;
  int tcnt    = 0;
  int irq_seen = 0;
  bit done    = 0;

  int q[$];
  int frame[$];
  bit irq_exp = 0;

  always #5 clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .nine_bit(nine_bit), .two_stop(two_stop),
    .irq_sel(irq_sel), .brk(brk), .txd(txd), .buf_full(buf_full),
    .tx_idle(tx_idle), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic bit model_idle();
    return q.size() == 0 && frame.size() == 0 && !brk;
  endfunction

  // One clock: compare outputs against the model, then advance the model.
  task automatic step();
    bit ho, push, ie;
    int w;
    baud_tick = (tcnt % div) == 0;
    tcnt++;
    #2;
    check("R8/R3 txd", txd, brk ? 1'b0 : (frame.size() > 0 ? 1'(frame[0]) : 1'b1));
    check("R2 buf_full", buf_full, q.size() == 4);
    check("R10 tx_idle", tx_idle, model_idle());
    check(irq_sel ? "R6 tx_irq" : "R5 tx_irq", tx_irq, irq_exp);
    if (tx_irq) irq_seen++;
    if (!rst_n) begin
      q.delete(); frame.delete(); irq_exp = 0;
    end else begin
      push = wr_en && q.size() < 4;
      ho   = baud_tick && !brk && q.size() > 0 && frame.size() <= 1;
      ie   = (q.size() == 1) && !push;
      irq_exp = ho && (!irq_sel || ie);
      if (baud_tick && frame.size() > 0) void'(frame.pop_front());
      if (ho) begin
        w = q.pop_front();
        frame.delete();
        frame.push_back(0);
        for (int i = 0; i < (nine_bit ? 9 : 8); i++) frame.push_back((w >> i) & 1);
        frame.push_back(1);
        if (two_stop) frame.push_back(1);
      end
      if (push) q.push_back(int'(wr_data));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input int d);
    wr_en = 1'b1; wr_data = 9'(d);
    step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && !(model_idle() && tx_idle); i++) step();
    step();
  endtask

  initial begin : main
    int base;
    @(negedge clk);
    run(3);
    // R1 reset state
    check("R1 txd", txd, 1'b1);
    check("R1 idle", tx_idle, 1'b1);
    check("R1 full", buf_full, 1'b0);
    check("R1 irq", tx_irq, 1'b0);
    rst_n = 1'b1;
    run(4);

    // R3 R5: single 8-bit frame, one stop bit
    put(9'h0A5);
    drain();
    // R3 R4 R5: 9-bit, two stops, back-to-back
    nine_bit = 1; two_stop = 1;
    put(9'h1C3); put(9'h055); put(9'h100);
    drain();
    // R6: drain-only policy
    nine_bit = 0; two_stop = 0; irq_sel = 1;
    base = irq_seen;
    put(9'h011); put(9'h022); put(9'h033);
    drain();
    check("R6 single drain pulse", 1'(irq_seen - base == 1), 1'b1);
    // R7: switch policy mid-stream
    put(9'h0F0); put(9'h00F); put(9'h0AA); put(9'h055);
    run(30);
    irq_sel = 0;
    drain();
    // R2 R9: fill during break, fifth write dropped, no irq
    brk = 1; base = irq_seen;
    put(1); put(2); put(3); put(4);
    check("R2 full after four", buf_full, 1'b1);
    put(5);
    run(13 * div + 4);
    check("R9 no irq in break", 1'(irq_seen == base), 1'b1);
    check("R8 line low in break", txd, 1'b0);
    brk = 0;
    #2 check("R9 line high after release", txd, 1'b1);
    drain();
    // R8: break in mid-frame
    put(9'h0FF);
    run(10);
    brk = 1;
    #2 check("R8 immediate low", txd, 1'b0);
    run(60);
    brk = 0;
    drain();
    // R6 R4: fast ticks, write lands on drain cycle
    div = 1; tcnt = 0; irq_sel = 1;
    put(9'h0C3);
    for (int k = 0; k < 12; k++) begin
      if (k == 9) put(9'h03C); else step();
    end
    drain();
    irq_sel = 0; two_stop = 1;
    put(9'h123); put(9'h1FE); put(9'h001); put(9'h080); put(9'h0EE);
    drain();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      done = 1;
      misses++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule